// File: doc/BRIEF.md
# Address-Decoded Set/Clear Video Control Register

This block sits on a CPU write bus and holds eleven single-bit control flags that configure a video fetch unit. A flag is never loaded from the data bus. It is changed by which address is written. Twenty-two consecutive byte addresses form a window of eleven even/odd pairs, one pair per flag. A write to the even address of a pair clears its flag, and a write to the odd address sets it. Software changes a multi-bit field by walking through the pairs one bit at a time. Each write picks the clear or the set address of the next bit.

The flags form three outputs. The first is a 3-bit display-mode field; the value 6 selects the full-height graphics memory size, and an external pin decides whether that is four-colour or two-colour. The second is a 7-bit display-start offset counted in 512-byte units. The third is one spare flag. The block also gives the byte address where the display buffer starts, taken from the offset, so an offset of 3 places the buffer at 0x0600.

Top module: `scr_setclr_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all eleven flags become 0 after that edge: `disp_mode`=0, `disp_start`=0, `aux_flag`=0, `disp_base`=0.
- R2: A write (`wr_en`=1) to window offset 2k+1 (address BASE+2k+1) sets flag k, and a write to offset 2k clears it. The new value is visible on the outputs after the same rising edge that captures the write.
- R3: The value on `wr_data` has no effect. A clear address still clears with data 0xFF, and a set address still sets with data 0x00.
- R4: Flags 0 to 2 (addresses BASE+0 to BASE+5) are `disp_mode` bits 0 to 2 in that order. For example, clearing bit 0 and setting bits 1 and 2 gives mode 3'b110.
- R5: Flags 3 to 9 (addresses BASE+6 to BASE+19) are `disp_start` bits 0 to 6 in that order. Bit n is cleared at BASE+6+2n and set at BASE+7+2n.
- R6: Flag 10 (clear at BASE+20, set at BASE+21) drives `aux_flag`.
- R7: A write to an address below BASE or at BASE+22 and above leaves every output unchanged. A cycle with `wr_en`=0 also leaves every output unchanged, whatever the address.
- R8: A single write changes at most one flag, and all other flags keep their value.
- R9: `disp_base` equals `disp_start` × 512 as a 16-bit byte address, so offset 3 gives 0x0600.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| wr_addr | input | 16 | Byte address of the write |
| wr_data | input | 8 | Write data, ignored |
| disp_mode | output | 3 | Display-mode field (flags 0..2) |
| disp_start | output | 7 | Display-start offset in 512-byte units (flags 3..9) |
| aux_flag | output | 1 | Spare control flag (flag 10) |
| disp_base | output | 16 | Byte address where the display buffer starts |

## Verification
The assertions check on every cycle that the decoder raises at most one set or clear request, and none outside the window or without a strobe. They also check that a set or clear request lands in its flag on the next cycle, that at most one flag toggles per cycle, that idle cycles hold every flag, and that reset zeroes the outputs. The bench scenarios are needed to show that specific addresses map to the right field bit and that mode 6 and offset 3 come out as 3'b110 and 0x0600. They also show that data values are ignored, and that addresses just outside both ends of the window do nothing.

// File: rtl/scr_pkg.sv
// Package: shared sizes for the set/clear control register.
// Assumes the window holds one even/odd address pair per flag.
package scr_pkg;
    localparam int unsigned MODE_W  = 3;
    localparam int unsigned START_W = 7;
    localparam int unsigned AUX_W   = 1;
    localparam int unsigned NFLAGS  = MODE_W + START_W + AUX_W;
    localparam int unsigned WIN_LEN = 2 * NFLAGS;
    localparam int unsigned PAGE_SH = 9;   // 512-byte units
endpackage

// File: rtl/scr_addr_decode.sv
// Module: window decoder. Turns one bus write into at most one set or clear
// request. Assumes the window does not wrap past the top of the address space.
module scr_addr_decode
    import scr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hFFC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NFLAGS-1:0] set_req,
    output logic [NFLAGS-1:0] clr_req
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_LEN);

    logic [ADDR_W-1:0] off;
    logic              hit;

    // Offset into the window and window hit.
    always_comb begin
        off = wr_addr - BASE;
        hit = wr_en && (wr_addr >= BASE) && (off < WIN);
    end

    // One request line per flag; address bit 0 picks set (odd) or clear (even).
    for (genvar i = 0; i < NFLAGS; i++) begin : g_req
        always_comb begin
            set_req[i] = hit && (off[ADDR_W-1:1] == (ADDR_W-1)'(i)) &&  off[0];
            clr_req[i] = hit && (off[ADDR_W-1:1] == (ADDR_W-1)'(i)) && !off[0];
        end
    end

    a_r8_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_req, clr_req}));
    a_r7_no_request_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr < BASE || wr_addr >= BASE + WIN) |-> ({set_req, clr_req} == '0));
endmodule

// File: rtl/scr_flag_bank.sv
// Module: bank of independent flag flops. Each flop is set or cleared by its own
// request line. Assumes the two requests of one flag are never high together.
module scr_flag_bank
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_req,
    input  logic [NFLAGS-1:0] clr_req,
    output logic [NFLAGS-1:0] flags
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_bit
        // Flag flop: sync reset, set wins over clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (set_req[i]) flags[i] <= 1'b1;
            else if (clr_req[i]) flags[i] <= 1'b0;
        end

        a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[i] |=> flags[i]);
        a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
            clr_req[i] |=> !flags[i]);
    end

    a_r8_one_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(flags ^ $past(flags)) <= 1));
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ({set_req, clr_req} == '0) |=> $stable(flags));
endmodule

// File: rtl/scr_setclr_ctrl.sv
// Module: top of the address-decoded set/clear video control register.
// It splits the flags into mode, start offset and spare, and forms the buffer
// byte address. Assumes one write per cycle and ignores write data.
module scr_setclr_ctrl
    import scr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 16'hFFC0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [MODE_W-1:0]  disp_mode,
    output logic [START_W-1:0] disp_start,
    output logic [AUX_W-1:0]   aux_flag,
    output logic [ADDR_W-1:0]  disp_base
);
    logic [NFLAGS-1:0] set_req;
    logic [NFLAGS-1:0] clr_req;
    logic [NFLAGS-1:0] flags;
    logic              data_unused;

    // Write data is deliberately not used.
    always_comb data_unused = ^wr_data;

    scr_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .set_req(set_req), .clr_req(clr_req)
    );

    scr_flag_bank u_bank (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
        .flags(flags)
    );

    // Field split and buffer byte address.
    always_comb begin
        disp_mode  = flags[MODE_W-1:0];
        disp_start = flags[MODE_W +: START_W];
        aux_flag   = flags[MODE_W+START_W +: AUX_W];
        disp_base  = ADDR_W'({disp_start, {PAGE_SH{1'b0}}});
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (disp_mode == '0 && disp_start == '0 && aux_flag == '0));
    a_r7_idle_holds_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(disp_mode) && $stable(disp_start) && $stable(aux_flag)));
endmodule

// File: tb/tb_scr_setclr_ctrl.sv
module tb_scr_setclr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  disp_mode;
    logic [6:0]  disp_start;
    logic [0:0]  aux_flag;
    logic [15:0] disp_base;

    localparam logic [15:0] B = 16'hFFC0;

    typedef struct {
        logic [10:0] fl;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [10:0] model = '0;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    scr_setclr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .disp_mode(disp_mode), .disp_start(disp_start),
        .aux_flag(aux_flag), .disp_base(disp_base)
    );

    task automatic compare(input logic [10:0] e, input string tag);
        logic [15:0] eb;
        eb = {e[9:3], 9'b0};
        n_tests++;
        if (disp_mode !== e[2:0] || disp_start !== e[9:3] ||
            aux_flag !== e[10] || disp_base !== eb) begin
            n_fail++;
            $display("FAIL %s: got mode=%b start=%h aux=%b base=%h, expected mode=%b start=%h aux=%b base=%h",
                     tag, disp_mode, disp_start, aux_flag, disp_base, e[2:0], e[9:3], e[10], eb);
        end
    endtask

    // Driver: one bus cycle, expected state pushed after the capturing edge.
    task automatic bus(input bit we, input logic [15:0] a, input logic [7:0] d, input string tag);
        exp_t it;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        if (we && a >= B && a < B + 16'd22)
            model[(a - B) >> 1] = (a[0] == (B[0] ^ 1'b1)) ? 1'b1 : 1'b0;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
        it.fl = model; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: pops and compares away from the active edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            compare(it.fl, it.tag);
        end
    end

    task automatic do_reset(input string tag);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        model = '0;
        compare(model, tag);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        // R4: mode 6 = clear bit0, set bit1, set bit2
        bus(1, B + 0, 8'h00, "R4 mode bit0 clear");
        bus(1, B + 3, 8'h00, "R4 mode bit1 set");
        bus(1, B + 5, 8'h00, "R4 mode bit2 set -> 110");
        // R5/R9: offset 3 -> base 0x0600
        bus(1, B + 7, 8'h00, "R5 start bit0 set");
        bus(1, B + 9, 8'h00, "R5 R9 start bit1 set -> base 0600");
        for (int n = 2; n < 7; n++)
            bus(1, B + 16'(6 + 2 * n), 8'h00, "R5 start high bits clear");
        bus(1, B + 19, 8'h5A, "R5 start bit6 set");
        bus(1, B + 18, 8'hA5, "R5 start bit6 clear");
        // R3: data ignored
        bus(1, B + 2, 8'hFF, "R3 clear with data FF");
        bus(1, B + 1, 8'h00, "R3 set with data 00");
        bus(1, B + 1, 8'hFF, "R3 set again with data FF");
        // R6: spare flag
        bus(1, B + 21, 8'h00, "R6 aux set");
        bus(1, B + 20, 8'hFF, "R6 aux clear");
        bus(1, B + 21, 8'h00, "R6 aux set again");
        // R7: outside window and idle strobe
        bus(1, B - 1,  8'h00, "R7 below window");
        bus(1, B + 22, 8'hFF, "R7 just past window");
        bus(1, B + 23, 8'hFF, "R7 past window odd");
        bus(1, 16'h0000, 8'hFF, "R7 far address");
        bus(0, B + 4,  8'h00, "R7 strobe low on clear addr");
        bus(0, B + 11, 8'hFF, "R7 strobe low on set addr");
        // R8/R2: set every flag one by one, then clear them one by one
        for (int k = 0; k < 11; k++)
            bus(1, B + 16'(2 * k + 1), 8'h00, "R8 R2 walking set");
        for (int k = 0; k < 11; k++)
            bus(1, B + 16'(2 * k), 8'hFF, "R8 R2 walking clear");
        bus(1, B + 13, 8'h00, "R9 start bit3 set -> base 1000");
        bus(1, B + 5,  8'h00, "R4 mode bit2 set");
        do_reset("R1 reset mid-run clears all");
        bus(0, B, 8'h00, "R1 stays zero after reset");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule